// File: doc/BRIEF.md
# Banked Data Memory Decoder

This block sits between a small CPU core and its 256-byte data space. Every access carries an 8-bit address, a write strobe, write data and a flag that marks an access made through the stack pointer. The block works out where each access lands and returns read data combinationally. The lower 128 addresses map onto one of several RAM banks. The upper 128 addresses hold a fixed register window that does not move with the bank selection. Locations that have no storage return a fill value.

The bank is chosen by a general register at 0xFF, which the core reads and writes like any other data byte. Stack-pointer accesses always use bank 0. Bank 0 is shorter than the other banks, because its top bytes are given over to unimplemented space above the stack. A parameter can turn banking off. The low half then always maps to bank 0, and the register at 0xFF holds plain data.

Top module: `banked_dmem`

## Requirements
- R1: After reset the registers at 0xEF and 0xF0..0xFF all read 0x00, which makes the bank select 0.
- R2: A write is stored at the next rising clock edge. Read data follows the address combinationally, so a read in the same cycle as a write returns the old content.
- R3: With banking on, addresses 0x00..0x7F reach the RAM bank whose number is held in the byte at 0xFF. Every bank keeps its own data.
- R4: Addresses 0xEF..0xFF return the same stored values whatever bank is selected.
- R5: When stack_acc is high, a low-half access uses bank 0 whatever the bank select holds.
- R6: Bank 0 stores only offsets below BANK0_SIZE (default 0x70). Higher offsets in bank 0 read 0xFF and ignore writes. Every other bank stores all offsets 0x00..0x7F.
- R7: With banking on, a bank select of NUM_BANKS (default 4) or more makes low-half non-stack reads return 0xFF and drops low-half writes.
- R8: Addresses 0x80..0xEE read 0xFF and ignore writes.
- R9: With BANKING_EN=0, low-half accesses always use bank 0, and the byte at 0xFF is ordinary storage with no effect on mapping.
- R10: Register Rn is byte 0xF0+n, the status byte is at 0xEF, and both can be written and read back through the data port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 8 | Data address |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| stack_acc | input | 1 | Access is made through the stack pointer |
| rdata | output | 8 | Combinational read data |

## Verification
The assertions assume that address, strobe and stack flag hold steady for the whole clock period and change only once per cycle. They also assume stack accesses matter only in the low half. The bench changes its inputs shortly after each rising edge and samples read data at the falling edge. It reads back only RAM bytes it has written, so no check depends on the unset contents of the arrays. A second instance with banking off receives the same stimulus, so the mapping with banking on and the mapping with banking off are compared from identical write histories.

// File: rtl/banked_dmem_pkg.sv
package banked_dmem_pkg;
  typedef enum logic [1:0] {
    RGN_RAM  = 2'd0,
    RGN_REGS = 2'd1,
    RGN_FILL = 2'd2
  } region_e;

  localparam logic [7:0] PSW_ADDR  = 8'hEF;
  localparam logic [7:0] FILL_BYTE = 8'hFF;
  localparam int         LOW_BYTES = 128;
  localparam int         NUM_REGS  = 17;
  localparam int         S_INDEX   = 15;
  localparam int         PSW_INDEX = 16;
endpackage

// File: rtl/dmem_rst_sync.sv
module dmem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_ns = sync_q[1];
endmodule

// File: rtl/dmem_decode.sv
module dmem_decode
  import banked_dmem_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK0_SIZE = 112,
  parameter bit BANKING_EN = 1'b1,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic [7:0]        addr,
  input  logic              stack_acc,
  input  logic [7:0]        s_value,
  output region_e           region,
  output logic [BANK_W-1:0] bank_idx,
  output logic [6:0]        ram_off,
  output logic [4:0]        reg_idx
);
  localparam logic [8:0] NB_LIM = 9'(NUM_BANKS);
  localparam logic [7:0] B0_LIM = 8'(BANK0_SIZE);

  logic [7:0] sel_bank;
  logic       bank_ok;
  logic       b0_short;

  always_comb begin
    sel_bank = (BANKING_EN && !stack_acc) ? s_value : 8'd0;
    bank_ok  = ({1'b0, sel_bank} < NB_LIM);
    b0_short = (sel_bank == 8'd0) && ({1'b0, addr[6:0]} >= B0_LIM);
    bank_idx = sel_bank[BANK_W-1:0];
    ram_off  = addr[6:0];
    reg_idx  = (addr == PSW_ADDR) ? 5'(PSW_INDEX) : {1'b0, addr[3:0]};
    if (!addr[7]) begin
      region = (bank_ok && !b0_short) ? RGN_RAM : RGN_FILL;
    end else if (addr >= PSW_ADDR) begin
      region = RGN_REGS;
    end else begin
      region = RGN_FILL;
    end
  end
endmodule

// File: rtl/dmem_bank_ram.sv
module dmem_bank_ram #(
  parameter int DEPTH = 128,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic       clk,
  input  logic       we,
  input  logic [6:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] idx;

  assign idx   = addr[AW-1:0];
  assign rdata = mem[idx];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end
endmodule

// File: rtl/dmem_regs.sv
module dmem_regs
  import banked_dmem_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [4:0] idx,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic [7:0] s_value
);
  logic [7:0] regs_q  [NUM_REGS];
  logic [7:0] regs_nx [NUM_REGS];

  always_comb begin
    for (int i = 0; i < NUM_REGS; i++) regs_nx[i] = regs_q[i];
    if (we && (int'(idx) < NUM_REGS)) regs_nx[idx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= 8'h00;
    end else if (we) begin
      for (int i = 0; i < NUM_REGS; i++) regs_q[i] <= regs_nx[i];
    end
  end

  assign rdata   = (int'(idx) < NUM_REGS) ? regs_q[idx] : 8'h00;
  assign s_value = regs_q[S_INDEX];

  // R10: a write to index 15 becomes the bank select one edge later
  p_s_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (we && idx == 5'd15) |=> (s_value == $past(wdata)));
endmodule

// File: rtl/banked_dmem.sv
module banked_dmem
  import banked_dmem_pkg::*;
#(
  parameter int NUM_BANKS  = 4,
  parameter int BANK0_SIZE = 112,
  parameter bit BANKING_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       stack_acc,
  output logic [7:0] rdata
);
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

  logic              rst_ns;
  region_e           region;
  logic [BANK_W-1:0] bank_idx;
  logic [6:0]        ram_off;
  logic [4:0]        reg_idx;
  logic [7:0]        s_value;
  logic [7:0]        reg_rd;
  logic              reg_we;
  logic [NUM_BANKS-1:0] bank_we;
  logic [7:0]        bank_rd [NUM_BANKS];

  dmem_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  dmem_decode #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK0_SIZE (BANK0_SIZE),
    .BANKING_EN (BANKING_EN)
  ) u_dec (
    .addr      (addr),
    .stack_acc (stack_acc),
    .s_value   (s_value),
    .region    (region),
    .bank_idx  (bank_idx),
    .ram_off   (ram_off),
    .reg_idx   (reg_idx)
  );

  assign reg_we = wr_en && (region == RGN_REGS);

  dmem_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_ns),
    .we      (reg_we),
    .idx     (reg_idx),
    .wdata   (wdata),
    .rdata   (reg_rd),
    .s_value (s_value)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    localparam int DEPTH_G = (g == 0) ? BANK0_SIZE : LOW_BYTES;
    assign bank_we[g] = wr_en && (region == RGN_RAM) && (bank_idx == BANK_W'(g));
    dmem_bank_ram #(.DEPTH(DEPTH_G)) u_ram (
      .clk   (clk),
      .we    (bank_we[g]),
      .addr  (ram_off),
      .wdata (wdata),
      .rdata (bank_rd[g])
    );
  end

  always_comb begin
    unique case (region)
      RGN_RAM:  rdata = bank_rd[bank_idx];
      RGN_REGS: rdata = reg_rd;
      default:  rdata = FILL_BYTE;
    endcase
  end

  // R3: at most one bank takes a write in any cycle
  p_one_bank_write_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    $onehot0(bank_we));

  // R5: stack accesses that reach RAM use bank 0
  p_stack_bank0_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (stack_acc && !addr[7] && region == RGN_RAM) |-> (bank_we[NUM_BANKS-1:1] == '0));

  // R7: a bank select beyond the implemented banks reads the fill byte
  p_oob_bank_fill_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (BANKING_EN && !addr[7] && !stack_acc && ({1'b0, s_value} >= 9'(NUM_BANKS)))
      |-> (rdata == 8'hFF && bank_we == '0));

  // R8: the unimplemented upper window reads 0xFF and stores nothing
  p_upper_fill_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    (addr[7] && addr < PSW_ADDR) |-> (rdata == 8'hFF && !reg_we && bank_we == '0));
endmodule

// File: tb/banked_dmem_test.sv
module banked_dmem_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       stack_acc = 1'b0;
  logic [7:0] rdata;
  logic [7:0] rdata_flat;

  int  checks = 0;
  int  bad = 0;
  bit  ended = 1'b0;

  logic [7:0] exp_q [$];
  bit         inst_q [$];
  string      tag_q [$];

  always #5 clk = ~clk;

  banked_dmem uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .stack_acc(stack_acc), .rdata(rdata)
  );

  banked_dmem #(.BANKING_EN(1'b0)) uut_flat (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .stack_acc(stack_acc), .rdata(rdata_flat)
  );

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic stk);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1; stack_acc = stk;
  endtask

  task automatic wr_chk(input logic [7:0] a, input logic [7:0] d,
                        input logic [7:0] old, input string tag);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1; stack_acc = 1'b0;
    exp_q.push_back(old); inst_q.push_back(1'b0); tag_q.push_back(tag);
  endtask

  task automatic rd(input logic [7:0] a, input logic stk, input logic [7:0] e,
                    input bit flat, input string tag);
    @(posedge clk); #1;
    addr = a; wr_en = 1'b0; stack_acc = stk;
    exp_q.push_back(e); inst_q.push_back(flat); tag_q.push_back(tag);
  endtask

  // monitor: pops one expected item per cycle at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [7:0] e;
      logic [7:0] got;
      bit         f;
      string      t;
      e = exp_q.pop_front();
      f = inst_q.pop_front();
      t = tag_q.pop_front();
      got = f ? rdata_flat : rdata;
      checks++;
      if (got !== e) begin
        bad++;
        $display("FAIL %s addr=%02h actual=%02h expected=%02h", t, addr, got, e);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!ended) begin
      ended = 1'b1;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset values
    rd(8'hFF, 1'b0, 8'h00, 1'b0, "R1 bank select");
    rd(8'hF0, 1'b0, 8'h00, 1'b0, "R1 register 0");
    rd(8'hEF, 1'b0, 8'h00, 1'b0, "R1 status byte");

    // R10: register window mapping
    wr(8'hF3, 8'h3C, 1'b0);
    rd(8'hF3, 1'b0, 8'h3C, 1'b0, "R10 register 3");
    wr(8'hEF, 8'hA5, 1'b0);
    rd(8'hEF, 1'b0, 8'hA5, 1'b0, "R10 status byte");

    // R2: same-cycle read shows old value, next cycle the new one
    wr_chk(8'hF3, 8'hC3, 8'h3C, "R2 old value during write");
    rd(8'hF3, 1'b0, 8'hC3, 1'b0, "R2 new value after edge");

    // R3: each bank keeps its own byte
    for (int b = 0; b < 4; b++) begin
      wr(8'hFF, 8'(b), 1'b0);
      wr(8'h10, 8'h40 + 8'(b), 1'b0);
    end
    for (int b = 0; b < 4; b++) begin
      wr(8'hFF, 8'(b), 1'b0);
      rd(8'h10, 1'b0, 8'h40 + 8'(b), 1'b0, "R3 per-bank data");
    end

    // R6: full bank reaches offset 0x7F; bank 0 stops at 0x70
    wr(8'hFF, 8'h01, 1'b0);
    wr(8'h7F, 8'h77, 1'b0);
    rd(8'h7F, 1'b0, 8'h77, 1'b0, "R6 top byte of bank 1");
    wr(8'hFF, 8'h00, 1'b0);
    wr(8'h70, 8'h11, 1'b0);
    rd(8'h70, 1'b0, 8'hFF, 1'b0, "R6 bank 0 hole");
    rd(8'h7F, 1'b0, 8'hFF, 1'b0, "R6 bank 0 top");
    rd(8'h75, 1'b1, 8'hFF, 1'b0, "R6 stack into hole");

    // R4: register window independent of bank select
    wr(8'hFF, 8'h02, 1'b0);
    rd(8'hF3, 1'b0, 8'hC3, 1'b0, "R4 register 3 under bank 2");
    rd(8'hEF, 1'b0, 8'hA5, 1'b0, "R4 status under bank 2");
    wr(8'hFF, 8'h09, 1'b0);
    rd(8'hF3, 1'b0, 8'hC3, 1'b0, "R4 register 3 under bad bank");

    // R5: stack accesses forced to bank 0
    wr(8'hFF, 8'h03, 1'b0);
    rd(8'h10, 1'b1, 8'h40, 1'b0, "R5 stack read bank 0");
    wr(8'h20, 8'h5A, 1'b1);
    wr(8'hFF, 8'h00, 1'b0);
    rd(8'h20, 1'b0, 8'h5A, 1'b0, "R5 stack write landed in bank 0");

    // R7: out-of-range bank select
    wr(8'hFF, 8'h04, 1'b0);
    rd(8'h10, 1'b0, 8'hFF, 1'b0, "R7 read bank 4");
    wr(8'h10, 8'h99, 1'b0);
    wr(8'hFF, 8'h80, 1'b0);
    rd(8'h10, 1'b0, 8'hFF, 1'b0, "R7 read bank 0x80");
    for (int b = 0; b < 4; b++) begin
      wr(8'hFF, 8'(b), 1'b0);
      rd(8'h10, 1'b0, 8'h40 + 8'(b), 1'b0, "R7 dropped write");
    end

    // R8: unimplemented upper window
    rd(8'h80, 1'b0, 8'hFF, 1'b0, "R8 read 0x80");
    wr(8'hA0, 8'h12, 1'b0);
    rd(8'hA0, 1'b0, 8'hFF, 1'b0, "R8 write ignored");
    rd(8'hEE, 1'b0, 8'hFF, 1'b0, "R8 read 0xEE");

    // R9: banking disabled instance
    wr(8'hFF, 8'h03, 1'b0);
    wr(8'h30, 8'h6B, 1'b0);
    wr(8'hFF, 8'h00, 1'b0);
    rd(8'h30, 1'b0, 8'h6B, 1'b1, "R9 flat bank 0");
    wr(8'hFF, 8'h80, 1'b0);
    rd(8'hFF, 1'b0, 8'h80, 1'b1, "R9 plain register");
    rd(8'h30, 1'b0, 8'h6B, 1'b1, "R9 no fill with large select");

    @(posedge clk); #1 wr_en = 1'b0;
    repeat (3) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule